// File: doc/BRIEF.md
# Packed Horizontal Pair Add/Subtract Unit

This unit takes two 128-bit source vectors and, inside each vector, combines every adjacent pair of elements into one result element. The results from the first source fill the lower half of the output vector and the results from the second source fill the upper half. Elements are either 16 bits (eight per vector, four pairs each) or 32 bits (four per vector, two pairs each). The pair is either summed or differenced, and for 16-bit elements the arithmetic either wraps or clamps to the signed range.

Callers present both sources, three operation select bits and a valid strobe in one cycle. The output vector and its valid flag are registered and appear on the next cycle. Nothing is accepted or produced when the strobe is low, and the last result stays on the output.

Top module: `hpair_unit`

## Requirements
- R1: With op_wide=0 and op_sub=0, output lane k (16 bits at bit 16k) for k in 0..3 is src_a lane 2k plus src_a lane 2k+1. For k in 4..7 it is src_b lane 2(k-4) plus src_b lane 2(k-4)+1.
- R2: With op_wide=1, output lane j (32 bits at bit 32j) for j in 0..1 combines src_a lanes 2j and 2j+1. For j in 2..3 it combines src_b lanes 2(j-2) and 2(j-2)+1.
- R3: With op_sub=1, each result is the lower-index element of the pair minus the higher-index element. The pair (1,2) gives -1.
- R4: With op_wide=0 and op_sat=0, 16-bit results wrap modulo 2^16. For example, 0x7FFF+1 gives 0x8000.
- R5: With op_wide=0 and op_sat=1, a 16-bit sum or difference above 32767 becomes 0x7FFF and one below -32768 becomes 0x8000. In-range results are unchanged.
- R6: With op_wide=1, 32-bit results wrap modulo 2^32, and op_sat has no effect on the output.
- R7: A result is captured on a clock edge where in_valid=1, and out_valid is high on exactly the cycle after each such edge. While in_valid=0, result holds its value.
- R8: A synchronous active-high rst clears out_valid and result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Capture strobe for the operands and selects |
| op_sub | input | 1 | 1 = difference (lower-index minus higher-index), 0 = sum |
| op_wide | input | 1 | 1 = 32-bit elements, 0 = 16-bit elements |
| op_sat | input | 1 | 1 = clamp 16-bit results to the signed range; ignored when op_wide=1 |
| src_a | input | 128 | First source vector; its pairs feed the low half of the result |
| src_b | input | 128 | Second source vector; its pairs feed the high half of the result |
| result | output | 128 | Registered packed result |
| out_valid | output | 1 | High on the cycle after a capture |

## Verification
The assertions assume that rst and in_valid are never X or Z once the clock runs. They also assume that the select bits are stable across the capture edge, because the clamp assertions link each lane's clamp flag to the value registered on that edge. The bench drives all inputs on the falling edge and holds them through the following rising edge. It starts in reset with every input at zero. It drives changing operands while in_valid is low so that the hold behaviour can be seen, and it reaches both clamp directions through pairs that overflow at the extremes of the signed range.

// File: rtl/hpair_pkg.sv
package hpair_pkg;
  // Decoded operation selects for one capture.
  typedef struct packed {
    logic sub;   // 1: lower minus higher element
    logic wide;  // 1: 32-bit elements
    logic sat;   // 1: clamp 16-bit results
  } hop_t;
endpackage

// File: rtl/hpair_pair_sat.sv
// One narrow pair: sum or difference with an optional signed clamp.
module hpair_pair_sat #(
  parameter int W = 16
) (
  input  logic [W-1:0] ev,
  input  logic [W-1:0] od,
  input  logic         sub,
  input  logic         sat_en,
  output logic [W-1:0] q,
  output logic         clip_hi,
  output logic         clip_lo
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  // One guard bit above the element width exposes any overflow.
  function automatic logic [W:0] ext_op(input logic [W-1:0] x, input logic [W-1:0] y,
                                        input logic s);
    logic [W:0] xe;
    logic [W:0] ye;
    xe = {x[W-1], x};
    ye = {y[W-1], y};
    return s ? (xe - ye) : (xe + ye);
  endfunction

  logic [W:0] full;

  always_comb begin
    full    = ext_op(ev, od, sub);
    clip_hi = sat_en & ~full[W] &  full[W-1];
    clip_lo = sat_en &  full[W] & ~full[W-1];
    if (clip_hi)      q = MAXV;
    else if (clip_lo) q = MINV;
    else              q = full[W-1:0];
  end
endmodule

// File: rtl/hpair_pair_wrap.sv
// One wide pair: sum or difference that wraps.
module hpair_pair_wrap #(
  parameter int W = 32
) (
  input  logic [W-1:0] ev,
  input  logic [W-1:0] od,
  input  logic         sub,
  output logic [W-1:0] q
);
  function automatic logic [W-1:0] wrap_op(input logic [W-1:0] x, input logic [W-1:0] y,
                                           input logic s);
    return s ? (x - y) : (x + y);
  endfunction

  assign q = wrap_op(ev, od, sub);
endmodule

// File: rtl/hpair_unit.sv
module hpair_unit
  import hpair_pkg::*;
#(
  parameter int VEC_W    = 128,
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             op_sub,
  input  logic             op_wide,
  input  logic             op_sat,
  input  logic [VEC_W-1:0] src_a,
  input  logic [VEC_W-1:0] src_b,
  output logic [VEC_W-1:0] result,
  output logic             out_valid
);
  localparam int N_NAR     = VEC_W / NARROW_W;
  localparam int HALF_NAR  = N_NAR / 2;
  localparam int N_WIDE    = VEC_W / WIDE_W;
  localparam int HALF_WIDE = N_WIDE / 2;

  hop_t op;
  assign op = '{sub: op_sub, wide: op_wide, sat: op_sat};

  logic             nar_sat_en;
  logic [VEC_W-1:0] nar_res;
  logic [VEC_W-1:0] wide_res;
  logic [N_NAR-1:0] clip_hi;
  logic [N_NAR-1:0] clip_lo;

  assign nar_sat_en = op.sat & ~op.wide;

  // Narrow lanes: low half from src_a pairs, high half from src_b pairs.
  for (genvar i = 0; i < N_NAR; i++) begin : g_nar
    localparam int P = i % HALF_NAR;
    logic [NARROW_W-1:0] ev;
    logic [NARROW_W-1:0] od;
    assign ev = (i < HALF_NAR) ? src_a[(2*P)*NARROW_W +: NARROW_W]
                               : src_b[(2*P)*NARROW_W +: NARROW_W];
    assign od = (i < HALF_NAR) ? src_a[(2*P+1)*NARROW_W +: NARROW_W]
                               : src_b[(2*P+1)*NARROW_W +: NARROW_W];
    hpair_pair_sat #(.W(NARROW_W)) u_pair (
      .ev(ev), .od(od), .sub(op.sub), .sat_en(nar_sat_en),
      .q(nar_res[i*NARROW_W +: NARROW_W]),
      .clip_hi(clip_hi[i]), .clip_lo(clip_lo[i])
    );
  end

  // Wide lanes: same split, 32-bit elements, wrapping only.
  for (genvar j = 0; j < N_WIDE; j++) begin : g_wide
    localparam int P = j % HALF_WIDE;
    logic [WIDE_W-1:0] ev;
    logic [WIDE_W-1:0] od;
    assign ev = (j < HALF_WIDE) ? src_a[(2*P)*WIDE_W +: WIDE_W]
                                : src_b[(2*P)*WIDE_W +: WIDE_W];
    assign od = (j < HALF_WIDE) ? src_a[(2*P+1)*WIDE_W +: WIDE_W]
                                : src_b[(2*P+1)*WIDE_W +: WIDE_W];
    hpair_pair_wrap #(.W(WIDE_W)) u_pair (
      .ev(ev), .od(od), .sub(op.sub),
      .q(wide_res[j*WIDE_W +: WIDE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= op.wide ? wide_res : nar_res;
    end
  end

  // Timing of the valid flag and hold of the result register.
  assert_valid_next_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));
  assert_reset_R8: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));

  // A lane never clamps in both directions at once.
  assert_clip_excl_R5: assert property (@(posedge clk) disable iff (rst)
    (clip_hi & clip_lo) == '0);

  // A clamp flag seen at capture must show up as the clamp value in that lane.
  for (genvar k = 0; k < N_NAR; k++) begin : g_chk
    assert_clip_hi_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && clip_hi[k]) |=> result[k*NARROW_W +: NARROW_W] == {1'b0, {(NARROW_W-1){1'b1}}});
    assert_clip_lo_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && clip_lo[k]) |=> result[k*NARROW_W +: NARROW_W] == {1'b1, {(NARROW_W-1){1'b0}}});
  end
endmodule

// File: tb/tb_hpair_unit.sv
module tb_hpair_unit;
  localparam int VW  = 128;
  localparam int NV  = 13;
  localparam int EW  = 3 + 3*VW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          op_sub = 1'b0;
  logic          op_wide = 1'b0;
  logic          op_sat = 1'b0;
  logic [VW-1:0] src_a = '0;
  logic [VW-1:0] src_b = '0;
  logic [VW-1:0] result;
  logic          out_valid;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  hpair_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .op_sub(op_sub), .op_wide(op_wide), .op_sat(op_sat),
    .src_a(src_a), .src_b(src_b), .result(result), .out_valid(out_valid)
  );

  localparam logic [VW-1:0] A1  = 128'h0008_0007_0006_0005_0004_0003_0002_0001;
  localparam logic [VW-1:0] B1  = 128'h0013_0006_000C_0018_0003_0004_0080_0004;
  localparam logic [VW-1:0] A2  = 128'h0004_7FFF_0003_7FFF_0002_7FFF_0001_7FFF;
  localparam logic [VW-1:0] B2  = 128'hFFFC_8000_FFFD_8000_FFFE_8000_FFFF_8000;
  localparam logic [VW-1:0] A4  = 128'hFFFC_7FFF_FFFD_7FFF_FFFE_7FFF_FFFF_7FFF;
  localparam logic [VW-1:0] B4  = 128'h0004_8000_0003_8000_0002_8000_0001_8000;
  localparam logic [VW-1:0] A6  = 128'h00000004_00000003_00000002_00000001;
  localparam logic [VW-1:0] B6  = 128'h00000003_00000004_00000080_00000004;
  localparam logic [VW-1:0] A8  = 128'h00000002_7FFFFFFF_00000001_7FFFFFFF;
  localparam logic [VW-1:0] B8  = 128'hFFFFFFFE_80000000_FFFFFFFF_80000000;
  localparam logic [VW-1:0] A9  = 128'hFFFFFFFE_7FFFFFFF_FFFFFFFF_7FFFFFFF;
  localparam logic [VW-1:0] B9  = 128'h00000002_80000000_00000001_80000000;
  localparam logic [VW-1:0] B10 = 128'hFFFF_8000_0001_7FFF_0003_0004_0080_0004;

  localparam logic [VW-1:0] E0  = 128'h0019_0024_0007_0084_000F_000B_0007_0003;
  localparam logic [VW-1:0] E1  = 128'hFFF3_000C_0001_FF84_FFFF_FFFF_FFFF_FFFF;
  localparam logic [VW-1:0] E2  = 128'h7FFC_7FFD_7FFE_7FFF_8003_8002_8001_8000;
  localparam logic [VW-1:0] E3  = 128'h8000_8000_8000_8000_7FFF_7FFF_7FFF_7FFF;
  localparam logic [VW-1:0] E6  = 128'h00000007_00000084_00000007_00000003;
  localparam logic [VW-1:0] E7  = 128'h00000001_FFFFFF84_FFFFFFFF_FFFFFFFF;
  localparam logic [VW-1:0] E8  = 128'h7FFFFFFE_7FFFFFFF_80000001_80000000;
  localparam logic [VW-1:0] E10 = 128'h8000_7FFF_0007_0084_000F_000B_0007_0003;

  // {op_sub, op_wide, op_sat}, src_a, src_b, expected
  localparam logic [EW-1:0] TAB [NV] = '{
    {3'b000, A1, B1,  E0},   // R1 sums
    {3'b100, A1, B1,  E1},   // R3 differences
    {3'b000, A2, B2,  E2},   // R4 wrap on sum
    {3'b001, A2, B2,  E3},   // R5 clamp on sum
    {3'b101, A4, B4,  E3},   // R5 clamp on difference
    {3'b100, A4, B4,  E2},   // R4 wrap on difference
    {3'b010, A6, B6,  E6},   // R2 wide sums
    {3'b110, A6, B6,  E7},   // R2 wide differences
    {3'b011, A8, B8,  E8},   // R6 wide wrap, sat set
    {3'b111, A9, B9,  E8},   // R6 wide wrap on difference, sat set
    {3'b001, A1, B10, E10},  // R5 clamp edge, in-range lanes unchanged
    {3'b010, A8, B8,  E8},   // R6 same wide case with sat clear
    {3'b001, A1, B1,  E0}    // R5 no clamp needed
  };

  function automatic string tag_of(input logic [2:0] op);
    if (op[1])      return "R2 R6";
    else if (op[0]) return "R5";
    else if (op[2]) return "R3 R4";
    else            return "R1 R4";
  endfunction

  task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input int k, input logic v);
    {op_sub, op_wide, op_sat} = TAB[k][EW-1 -: 3];
    src_a    = TAB[k][3*VW-1 -: VW];
    src_b    = TAB[k][2*VW-1 -: VW];
    in_valid = v;
  endtask

  initial begin : watchdog
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [VW-1:0] held;
    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8 reset result", result, '0);
    check("R8 reset out_valid", {127'd0, out_valid}, 128'd1 - 128'd1);
    rst = 1'b0;
    @(negedge clk);

    // Table walk: capture, check result and valid, then valid drops.
    for (int k = 0; k < NV; k++) begin
      drive(k, 1'b1);
      @(negedge clk);
      in_valid = 1'b0;
      check(tag_of(TAB[k][EW-1 -: 3]), result, TAB[k][VW-1:0]);
      check("R7 out_valid high after capture", {127'd0, out_valid}, 128'd1);
      @(negedge clk);
      check("R7 out_valid low when idle", {127'd0, out_valid}, 128'd0);
    end

    // R7: inputs change with in_valid low; result must hold.
    held = result;
    drive(0, 1'b0);
    @(negedge clk);
    drive(6, 1'b0);
    @(negedge clk);
    check("R7 hold result", result, held);
    check("R7 hold out_valid", {127'd0, out_valid}, 128'd0);

    // R7: back-to-back captures.
    drive(1, 1'b1);
    @(negedge clk);
    check("R7 R3 first back-to-back", result, E1);
    drive(7, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 R2 second back-to-back", result, E7);
    check("R7 valid stays high", {127'd0, out_valid}, 128'd1);
    @(negedge clk);

    // R8: reset right after a capture clears both outputs.
    drive(2, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R8 reset clears result", result, '0);
    check("R8 reset clears out_valid", {127'd0, out_valid}, 128'd0);
    rst = 1'b0;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule